// File: doc/BRIEF.md
# Chipset Configuration and Upper-Memory Shadow Controller

This block is the configuration corner of a 486-class system chipset. Software reaches a sparse 256-entry register space through two 8-bit I/O ports. One port selects a register number and the other reads or writes the selected register. A range of these registers is writable. One register is a fixed identification byte. Six of the writable registers set how the upper-memory area from 0xA0000 to 0xFFFFF is routed. Each 16 KB segment of that area carries a 2-bit code. One code bit sends reads to on-board DRAM instead of the expansion bus, and the other bit does the same for writes.

A combinational decoder turns a 20-bit CPU address and a read/write flag into a region hit and a route-to-internal-memory signal, with no clock of latency. Two further I/O ports have side effects. One of them opens or closes the address-line-20 gate, depending on whether it is read or written. The other, when read, asks the CPU for a soft reset.

The side effects are handled by two small state machines. The gate machine has the states GATE_CLOSED and GATE_OPEN. A read of the gate port takes it from GATE_CLOSED to GATE_OPEN, and a write takes it from GATE_OPEN to GATE_CLOSED. Any other access leaves it where it is. The reset-request machine has the states RQ_IDLE and RQ_FIRE. A read of the reset port takes it from RQ_IDLE to RQ_FIRE. A cycle without that read takes it from RQ_FIRE back to RQ_IDLE, and a further read keeps it in RQ_FIRE.

Top module: `cfg_shadow_ctl`

## Requirements
- R1: A write to I/O port 0xEC loads the 8-bit register number. A read of 0xEC returns it in the same cycle as the read strobe.
- R2: A write to data port 0xED stores the byte only when the register number is 0x01 to 0x24 inclusive. At any other number the write has no effect. Reading a number above 0x24 returns 0x00.
- R3: Register number 0x00 always reads as 0x90 through port 0xED, and writes to it are ignored.
- R4: Registers 0x0D to 0x12 control the 64 KB blocks at 0xA0000, 0xB0000, 0xC0000, 0xD0000, 0xE0000 and 0xF0000 in that order. The 16 KB segment s of a block, counted upward from 0 by address bits [15:14], is set by register bits [2s+1:2s].
- R5: The segment code sets the route. Code 0 sends reads and writes to the external bus. Code 1 sends reads external and writes internal. Code 2 sends reads internal and writes external. Code 3 sends both internal. route_internal follows the bit that mem_wr selects.
- R6: Addresses below 0xA0000 give mem_in_region = 0 and route_internal = 0 whatever the registers hold. Addresses 0xA0000 to 0xFFFFF give mem_in_region = 1.
- R7: A write to port 0xEE clears a20_en from the next cycle on. A read of 0xEE sets it. If a read and a write of 0xEE fall in the same cycle, the write wins. a20_en does not change without an access to 0xEE.
- R8: A read of port 0xEF raises soft_rst in the following cycle. soft_rst stays high for one cycle per read cycle, and it is high only after such a read.
- R9: Reads of ports 0xEE and 0xEF, and of any port other than 0xEC and 0xED, return 0xFF.
- R10: After reset, the register number is 0, all writable registers are 0 so that every segment routes externally, a20_en is 0 and soft_rst is 0.
- R11: The route decode is combinational. route_internal reflects a new mem_addr or mem_wr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe, one access per cycle high |
| io_rd | input | 1 | I/O read strobe, one access per cycle high |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational from io_addr |
| a20_en | output | 1 | Address-line-20 gate level |
| soft_rst | output | 1 | One-cycle CPU soft reset request |
| mem_addr | input | 20 | CPU memory address to classify |
| mem_wr | input | 1 | 1 for a write access, 0 for a read |
| mem_in_region | output | 1 | Address lies in 0xA0000 to 0xFFFFF |
| route_internal | output | 1 | Access goes to internal DRAM |

## Verification
The decoder is programmed with six register values that differ on purpose. One block holds codes 0 to 3 in rising segment order and another holds them in falling order. This shows that segment positions are not swapped and that each address maps to the right register. Two further blocks are uniform with code 2 and code 1, so the read bit and the write bit are separated. Each code is probed at the low edge and the high edge of its segment, under both read and write. This shows that each read and write selects its own code bit. Addresses just below the region and at address zero confirm that the decoder ignores register contents outside the region. The register port is tried at number 0x00, at both ends of the writable range, and just past it, to find the write-enable boundaries.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;

    // Kind of I/O access seen in one cycle
    typedef enum logic [2:0] {
        IOK_NONE,
        IOK_SEL_WR,
        IOK_DATA_WR,
        IOK_GATE_WR,
        IOK_GATE_RD,
        IOK_RST_RD,
        IOK_OTHER
    } io_kind_e;

    typedef enum logic {
        GATE_CLOSED,
        GATE_OPEN
    } gate_state_e;

    typedef enum logic {
        RQ_IDLE,
        RQ_FIRE
    } rq_state_e;

    localparam int SEGS_PER_BLOCK = 4;
    localparam int CODE_W         = 2;

endpackage

// File: rtl/cfgsh_regfile.sv
module cfgsh_regfile
    import cfgsh_pkg::*;
#(
    parameter logic [7:0] ID_VALUE   = 8'h90,
    parameter logic [7:0] WR_LO      = 8'h01,
    parameter logic [7:0] WR_HI      = 8'h24,
    parameter logic [7:0] SHADOW_IDX = 8'h0D,
    parameter int         NUM_BLOCKS = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_we,
    input  logic                    data_we,
    input  logic [7:0]              wdata,
    output logic [7:0]              sel_q,
    output logic [7:0]              data_rd,
    output logic [NUM_BLOCKS*8-1:0] shadow_flat
);

    localparam int NUM_REGS = int'(WR_HI) - int'(WR_LO) + 1;
    localparam int OFF_W    = $clog2(NUM_REGS);
    localparam int TAP0     = int'(SHADOW_IDX) - int'(WR_LO);

    logic [7:0]       store_q [NUM_REGS];
    logic [7:0]       off;
    logic             in_range;

    assign off      = sel_q - WR_LO;
    assign in_range = (sel_q >= WR_LO) && (sel_q <= WR_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                store_q[i] <= '0;
            end
        end else if (data_we && in_range) begin
            store_q[off[OFF_W-1:0]] <= wdata;
        end
    end

    always_comb begin
        if (sel_q == 8'h00) begin
            data_rd = ID_VALUE;
        end else if (in_range) begin
            data_rd = store_q[off[OFF_W-1:0]];
        end else begin
            data_rd = 8'h00;
        end
    end

    for (genvar k = 0; k < NUM_BLOCKS; k++) begin : g_tap
        assign shadow_flat[k*8 +: 8] = store_q[TAP0 + k];
    end

endmodule

// File: rtl/cfgsh_side_fsm.sv
module cfgsh_side_fsm
    import cfgsh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_close_req,
    input  logic gate_open_req,
    input  logic reset_req,
    output logic a20_en,
    output logic soft_rst
);

    gate_state_e gate_q, gate_d;
    rq_state_e   rq_q, rq_d;

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= GATE_CLOSED;
            rq_q   <= RQ_IDLE;
        end else begin
            gate_q <= gate_d;
            rq_q   <= rq_d;
        end
    end

    // Next-state logic; a write (close) outranks a read (open)
    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_CLOSED: if (gate_open_req && !gate_close_req) gate_d = GATE_OPEN;
            GATE_OPEN:   if (gate_close_req)                   gate_d = GATE_CLOSED;
            default:     gate_d = GATE_CLOSED;
        endcase
    end

    always_comb begin
        rq_d = rq_q;
        unique case (rq_q)
            RQ_IDLE: if (reset_req)  rq_d = RQ_FIRE;
            RQ_FIRE: if (!reset_req) rq_d = RQ_IDLE;
            default: rq_d = RQ_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        a20_en   = (gate_q == GATE_OPEN);
        soft_rst = (rq_q == RQ_FIRE);
    end

endmodule

// File: rtl/cfgsh_mem_decode.sv
module cfgsh_mem_decode
    import cfgsh_pkg::*;
#(
    parameter int         NUM_BLOCKS = 6,
    parameter logic [3:0] BASE_NIB   = 4'hA
) (
    input  logic [19:0]             mem_addr,
    input  logic                    mem_wr,
    input  logic [NUM_BLOCKS*8-1:0] shadow_flat,
    output logic                    in_region,
    output logic                    route_internal
);

    localparam logic [4:0] NB5 = 5'(NUM_BLOCKS);

    logic [3:0]        rel;
    logic [1:0]        seg;
    logic [CODE_W-1:0] code;

    assign rel       = mem_addr[19:16] - BASE_NIB;
    assign seg       = mem_addr[15:14];
    assign in_region = (mem_addr[19:16] >= BASE_NIB) && ({1'b0, rel} < NB5);

    always_comb begin
        code = '0;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            for (int s = 0; s < SEGS_PER_BLOCK; s++) begin
                if (rel == 4'(b) && seg == 2'(s)) begin
                    code = shadow_flat[b*8 + s*CODE_W +: CODE_W];
                end
            end
        end
    end

    // bit 0: writes internal, bit 1: reads internal
    assign route_internal = in_region && (mem_wr ? code[0] : code[1]);

endmodule

// File: rtl/cfg_shadow_ctl.sv
module cfg_shadow_ctl
    import cfgsh_pkg::*;
#(
    parameter logic [15:0] PORT_SEL   = 16'h00EC,
    parameter logic [15:0] PORT_DATA  = 16'h00ED,
    parameter logic [15:0] PORT_GATE  = 16'h00EE,
    parameter logic [15:0] PORT_RST   = 16'h00EF,
    parameter logic [7:0]  ID_VALUE   = 8'h90,
    parameter int          NUM_BLOCKS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        a20_en,
    output logic        soft_rst,
    input  logic [19:0] mem_addr,
    input  logic        mem_wr,
    output logic        mem_in_region,
    output logic        route_internal
);

    io_kind_e                kind;
    logic [7:0]              sel_q;
    logic [7:0]              data_rd;
    logic [NUM_BLOCKS*8-1:0] shadow_flat;
    logic                    gate_wr_hit;
    logic                    gate_rd_hit;

    // Classify the write side of the access
    always_comb begin
        kind = IOK_NONE;
        if (io_wr) begin
            unique case (io_addr)
                PORT_SEL:  kind = IOK_SEL_WR;
                PORT_DATA: kind = IOK_DATA_WR;
                PORT_GATE: kind = IOK_GATE_WR;
                default:   kind = IOK_OTHER;
            endcase
        end else if (io_rd) begin
            unique case (io_addr)
                PORT_GATE: kind = IOK_GATE_RD;
                PORT_RST:  kind = IOK_RST_RD;
                default:   kind = IOK_OTHER;
            endcase
        end
    end

    assign gate_wr_hit = (kind == IOK_GATE_WR);
    assign gate_rd_hit = (kind == IOK_GATE_RD);

    cfgsh_regfile #(
        .ID_VALUE   (ID_VALUE),
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_we      (kind == IOK_SEL_WR),
        .data_we     (kind == IOK_DATA_WR),
        .wdata       (io_wdata),
        .sel_q       (sel_q),
        .data_rd     (data_rd),
        .shadow_flat (shadow_flat)
    );

    cfgsh_side_fsm u_side (
        .clk            (clk),
        .rst_n          (rst_n),
        .gate_close_req (gate_wr_hit),
        .gate_open_req  (gate_rd_hit),
        .reset_req      (io_rd && io_addr == PORT_RST && !io_wr),
        .a20_en         (a20_en),
        .soft_rst       (soft_rst)
    );

    cfgsh_mem_decode #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_dec (
        .mem_addr       (mem_addr),
        .mem_wr         (mem_wr),
        .shadow_flat    (shadow_flat),
        .in_region      (mem_in_region),
        .route_internal (route_internal)
    );

    // Read-data mux
    always_comb begin
        if (io_addr == PORT_SEL) begin
            io_rdata = sel_q;
        end else if (io_addr == PORT_DATA) begin
            io_rdata = data_rd;
        end else begin
            io_rdata = 8'hFF;
        end
    end

endmodule

// File: rtl/cfgsh_checker.sv
module cfgsh_checker #(
    parameter logic [15:0] PORT_SEL  = 16'h00EC,
    parameter logic [15:0] PORT_DATA = 16'h00ED,
    parameter logic [15:0] PORT_GATE = 16'h00EE,
    parameter logic [15:0] PORT_RST  = 16'h00EF
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        a20_en,
    input logic        soft_rst,
    input logic        mem_in_region,
    input logic        route_internal,
    input logic [7:0]  sel_q
);

    assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == PORT_SEL) |=> (sel_q == $past(io_wdata)));

    assert_id_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == PORT_DATA && sel_q == 8'h00) |-> (io_rdata == 8'h90));

    assert_outside_external_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_in_region |-> !route_internal);

    assert_gate_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == PORT_GATE) |=> !a20_en);

    assert_gate_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == PORT_GATE) |=> a20_en);

    assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((io_rd || io_wr) && io_addr == PORT_GATE) |=> $stable(a20_en));

    assert_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(io_rd && !io_wr && io_addr == PORT_RST));

    assert_side_ports_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == PORT_GATE || io_addr == PORT_RST) |-> (io_rdata == 8'hFF));

endmodule

bind cfg_shadow_ctl cfgsh_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .io_addr        (io_addr),
    .io_wr          (io_wr),
    .io_rd          (io_rd),
    .io_wdata       (io_wdata),
    .io_rdata       (io_rdata),
    .a20_en         (a20_en),
    .soft_rst       (soft_rst),
    .mem_in_region  (mem_in_region),
    .route_internal (route_internal),
    .sel_q          (sel_q)
);

// File: tb/cfg_shadow_ctl_bench.sv
module cfg_shadow_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] io_addr;
    logic        io_wr;
    logic        io_rd;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic        a20_en;
    logic        soft_rst;
    logic [19:0] mem_addr;
    logic        mem_wr;
    logic        mem_in_region;
    logic        route_internal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cfg_shadow_ctl u_cfg_shadow_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .io_addr        (io_addr),
        .io_wr          (io_wr),
        .io_rd          (io_rd),
        .io_wdata       (io_wdata),
        .io_rdata       (io_rdata),
        .a20_en         (a20_en),
        .soft_rst       (soft_rst),
        .mem_addr       (mem_addr),
        .mem_wr         (mem_wr),
        .mem_in_region  (mem_in_region),
        .route_internal (route_internal)
    );

    // {address, write flag, expected route_internal, expected in_region}
    localparam int NV = 20;
    localparam logic [22:0] VEC [NV] = '{
        {20'hA0000, 1'b0, 1'b0, 1'b1},
        {20'hA0000, 1'b1, 1'b0, 1'b1},
        {20'hA4000, 1'b0, 1'b0, 1'b1},
        {20'hA7FFF, 1'b1, 1'b1, 1'b1},
        {20'hA8000, 1'b0, 1'b1, 1'b1},
        {20'hA8000, 1'b1, 1'b0, 1'b1},
        {20'hAC000, 1'b0, 1'b1, 1'b1},
        {20'hAFFFF, 1'b1, 1'b1, 1'b1},
        {20'hB0000, 1'b1, 1'b1, 1'b1},
        {20'hB4000, 1'b0, 1'b1, 1'b1},
        {20'hB4000, 1'b1, 1'b0, 1'b1},
        {20'hB8000, 1'b0, 1'b0, 1'b1},
        {20'hBFFFF, 1'b0, 1'b0, 1'b1},
        {20'hC7FFF, 1'b0, 1'b1, 1'b1},
        {20'hD2000, 1'b1, 1'b0, 1'b1},
        {20'hE0000, 1'b0, 1'b1, 1'b1},
        {20'hEC000, 1'b1, 1'b0, 1'b1},
        {20'hFFFFF, 1'b1, 1'b1, 1'b1},
        {20'h9FFFF, 1'b0, 1'b0, 1'b0},
        {20'h00000, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(16'h00EC, idx);
        io_write(16'h00ED, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        io_write(16'h00EC, idx);
        io_read(16'h00ED, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
        mem_addr = '0; mem_wr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        chk("R10 a20_en", 32'(a20_en), 32'd0);
        chk("R10 soft_rst", 32'(soft_rst), 32'd0);
        for (int b = 0; b < 6; b++) begin
            mem_addr = 20'hA0000 + 20'(b) * 20'h10000 + 20'h8000; mem_wr = 1'b0;
            #1 chk("R10 route after reset rd", 32'(route_internal), 32'd0);
            mem_wr = 1'b1;
            #1 chk("R10 route after reset wr", 32'(route_internal), 32'd0);
        end
        io_read(16'h00EC, d);
        chk("R10 index after reset", 32'(d), 32'h00);

        // R3: identification register, write ignored
        io_read(16'h00ED, d);
        chk("R3 id read", 32'(d), 32'h90);
        io_write(16'h00ED, 8'h55);
        io_read(16'h00ED, d);
        chk("R3 id after write", 32'(d), 32'h90);

        // R1: index readback
        io_write(16'h00EC, 8'hC3);
        io_read(16'h00EC, d);
        chk("R1 index readback", 32'(d), 32'hC3);

        // R2: range boundaries
        reg_write(8'h01, 8'hA5);
        reg_read(8'h01, d);
        chk("R2 low end stored", 32'(d), 32'hA5);
        reg_write(8'h24, 8'h3C);
        reg_read(8'h24, d);
        chk("R2 high end stored", 32'(d), 32'h3C);
        reg_write(8'h25, 8'h77);
        reg_read(8'h25, d);
        chk("R2 past range ignored", 32'(d), 32'h00);
        reg_read(8'h24, d);
        chk("R2 neighbour untouched", 32'(d), 32'h3C);

        // R4/R5: program the six routing registers
        reg_write(8'h0D, 8'hE4);
        reg_write(8'h0E, 8'h1B);
        reg_write(8'h0F, 8'hFF);
        reg_write(8'h10, 8'h00);
        reg_write(8'h11, 8'hAA);
        reg_write(8'h12, 8'h55);
        reg_read(8'h0E, d);
        chk("R4 routing register readback", 32'(d), 32'h1B);

        // R4 R5 R6 R11: table walk, combinational decode
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            mem_addr = VEC[i][22:3];
            mem_wr   = VEC[i][2];
            #1;
            chk($sformatf("R5 R11 route at %05h wr=%0d", VEC[i][22:3], VEC[i][2]),
                32'(route_internal), 32'(VEC[i][1]));
            chk($sformatf("R6 region at %05h", VEC[i][22:3]),
                32'(mem_in_region), 32'(VEC[i][0]));
        end

        // R6: full registers do not leak below the region
        reg_write(8'h0D, 8'hFF);
        mem_addr = 20'h9C000; mem_wr = 1'b1;
        #1 chk("R6 below region with codes 3", 32'(route_internal), 32'd0);

        // R7: gate port
        io_read(16'h00EE, d);
        chk("R9 gate port reads FF", 32'(d), 32'hFF);
        chk("R7 read opens gate", 32'(a20_en), 32'd1);
        io_read(16'h00EE, d);
        chk("R7 second read keeps open", 32'(a20_en), 32'd1);
        io_write(16'h0080, 8'h00);
        chk("R7 other port no effect", 32'(a20_en), 32'd1);
        io_write(16'h00EE, 8'h00);
        chk("R7 write closes gate", 32'(a20_en), 32'd0);
        io_write(16'h00EE, 8'h00);
        chk("R7 second write keeps closed", 32'(a20_en), 32'd0);

        // R8: soft reset pulse
        chk("R8 idle before read", 32'(soft_rst), 32'd0);
        io_read(16'h00EF, d);
        chk("R9 reset port reads FF", 32'(d), 32'hFF);
        chk("R8 pulse high", 32'(soft_rst), 32'd1);
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(soft_rst), 32'd0);

        // R9: undefined port
        io_read(16'h0080, d);
        chk("R9 other port reads FF", 32'(d), 32'hFF);

        // R10: reset again restores defaults
        io_read(16'h00EE, d);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R10 a20 after re-reset", 32'(a20_en), 32'd0);
        mem_addr = 20'hC0000; mem_wr = 1'b0;
        #1 chk("R10 route after re-reset", 32'(route_internal), 32'd0);
        reg_read(8'h12, d);
        chk("R10 register cleared", 32'(d), 32'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule